// File: doc/BRIEF.md
# Watchdog Timer with Reset or NMI Time-out

A free-running watchdog for a CPU subsystem. After power-on it sits idle; software turns it on by setting the enable bit of an 8-bit control register. Software also picks one of four power-of-two time-out lengths, and chooses whether a time-out produces a fixed-width system reset pulse or a one-cycle nonmaskable interrupt. Once on, the watchdog cannot be switched off by software. It must be serviced by a two-byte key sequence written to a separate refresh address, which restarts the count from zero.

Every time-out sets a sticky cause flag in the control register. That flag survives the system reset that the watchdog itself triggers, so boot code can find out why the CPU restarted. Only a power-on reset clears the flag, or software writing 1 to it. The register bus is a plain single-cycle select/write strobe with combinational read data. There is no data stream here, so there is no valid/ready handshake; every pin is a plain control or status level.

Two reset inputs are provided. `por_n` clears everything. `sys_rst_n` is the system reset: it clears the enable, the configuration and the count, but keeps the cause flag, and it does not cut short a reset pulse already in progress.

Top module: `wdog_nmi_timer`

## Requirements
- R1: After `por_n` is released, a read of the control register (address 0) returns 0x00 and both `rst_pulse_o` and `nmi_o` are low. While the enable bit is 0, no time-out ever occurs.
- R2: Control bit 7 is the enable. Writing 1 sets it. Writing 0 while it is set has no effect. Only `sys_rst_n` or `por_n` clears it.
- R3: Control bits [1:0] select a time-out length of 2^EXP0, 2^EXP1, 2^EXP2 or 2^EXP3 clock cycles (defaults 18, 22, 25, 27). The time-out output rises exactly that many cycles after the clock edge that accepted the enabling write or the last refresh.
- R4: Control bit 6 is the cause flag. It reads 1 from the edge of a time-out onward, and it is cleared by writing 1 to bit 6. If a time-out and a clearing write land in the same cycle, the time-out wins.
- R5: With control bit 5 at 0, a time-out raises `rst_pulse_o` at a clock edge and holds it high for exactly 64 cycles (parameter RST_W). The pulse falls at a clock edge.
- R6: With control bit 5 at 1, a time-out raises `nmi_o` for exactly one cycle and leaves `rst_pulse_o` low.
- R7: Writing 0xA5 and then 0x5A to the refresh address (address 1) restarts the count from zero at the edge that accepts the 0x5A.
- R8: Any other refresh traffic does not restart the count. A lone 0x5A, or a 0xA5 followed by any byte other than 0x5A, is ignored, and a wrong byte cancels a pending 0xA5.
- R9: The cause flag keeps its value through `sys_rst_n`, and `por_n` clears it. A `rst_pulse_o` pulse runs to its full length even if `sys_rst_n` is asserted during it.
- R10: After every time-out the count restarts from zero, so a watchdog left unserviced in NMI mode fires again one full period later.
- R11: Control bits [4:2] are reserved and always read 0. A read of the refresh address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; keeps cause flag and running pulse |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | ADDR_W | Register address: 0 control, 1 refresh |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| rst_pulse_o | output | 1 | System reset request, high for RST_W cycles after a time-out |
| nmi_o | output | 1 | One-cycle nonmaskable interrupt request |

## Verification
A time-out output rises exactly 2^N cycles after the edge that accepted the enabling write or the refresh 0x5A. The reset pulse falls RST_W cycles after it rose, and the NMI falls one cycle after it rose. Control reads are combinational and are due in the same cycle. The bench stamps the accepting edge of each write with a running cycle count and queues the cycle numbers at which each output edge is due. A monitor sampling on the falling clock edge compares every observed output transition against the head of that queue, so an output change that is early, late or unexpected is reported.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned DW = 8;

  // refresh key bytes, in the order they must arrive
  localparam logic [DW-1:0] KEY_ARM  = 8'hA5;
  localparam logic [DW-1:0] KEY_FIRE = 8'h5A;

  // control register layout, msb first
  typedef struct packed {
    logic       en;
    logic       flag;
    logic       nmi_sel;
    logic [2:0] rsvd;
    logic [1:0] per;
  } ctrl_t;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          wr_ctrl_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          timeout_i,
  output ctrl_t         ctrl_o
);

  logic       en_q;
  logic       nmi_sel_q;
  logic [1:0] per_q;
  logic       flag_q;
  logic       unused_rsvd;

  assign unused_rsvd = ^wdata_i[4:2];

  // configuration: cleared by either reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      nmi_sel_q <= 1'b0;
      per_q     <= 2'd0;
    end else if (wr_ctrl_i) begin
      en_q      <= en_q | wdata_i[7];
      nmi_sel_q <= wdata_i[5];
      per_q     <= wdata_i[1:0];
    end
  end

  // cause flag: survives system reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      flag_q <= 1'b0;
    else if (timeout_i)
      flag_q <= 1'b1;
    else if (wr_ctrl_i && wdata_i[6])
      flag_q <= 1'b0;
  end

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.en      = en_q;
    ctrl_o.flag    = flag_q;
    ctrl_o.nmi_sel = nmi_sel_q;
    ctrl_o.per     = per_q;
  end

  p_en_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_q) |-> en_q);

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!por_n)
    timeout_i |=> flag_q);

  p_flag_clear_r4: assert property (@(posedge clk) disable iff (!por_n)
    (wr_ctrl_i && wdata_i[6] && !timeout_i) |=> !flag_q);

endmodule

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_kick_i,
  input  logic [DW-1:0] wdata_i,
  output logic          kick_o
);

  logic armed_q;

  assign kick_o = wr_kick_i && armed_q && (wdata_i == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      armed_q <= 1'b0;
    else if (wr_kick_i)
      armed_q <= (wdata_i == KEY_ARM);
  end

  p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kick_i && wdata_i != KEY_ARM) |=> !armed_q);

  p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kick_i && wdata_i == KEY_ARM) |=> armed_q);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned EXP0 = 18,
  parameter int unsigned EXP1 = 22,
  parameter int unsigned EXP2 = 25,
  parameter int unsigned EXP3 = 27,
  parameter int unsigned CW   = 27
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [1:0] per_i,
  input  logic       kick_i,
  output logic       timeout_o
);

  localparam int unsigned NPER = 4;
  localparam int unsigned EXPS [NPER] = '{EXP0, EXP1, EXP2, EXP3};

  logic [CW-1:0] lim [NPER];
  logic [CW-1:0] cnt_q;

  for (genvar g = 0; g < NPER; g++) begin : g_lim
    assign lim[g] = CW'((64'd1 << EXPS[g]) - 64'd1);
  end

  assign timeout_o = en_i && (cnt_q >= lim[per_i]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (timeout_o || kick_i)
      cnt_q <= '0;
    else if (en_i)
      cnt_q <= cnt_q + 1'b1;
  end

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> cnt_q == '0);

  p_kick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> cnt_q == '0);

  p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !timeout_o && !kick_i) |=> cnt_q == $past(cnt_q) + 1'b1);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !kick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned RST_W = 64
) (
  input  logic clk,
  input  logic por_n,
  input  logic timeout_i,
  input  logic nmi_sel_i,
  output logic rst_o,
  output logic nmi_o
);

  localparam int unsigned RW = $clog2(RST_W + 1);
  localparam int unsigned HW = RW + 2;

  logic [RW-1:0] rem_q, rem_d;
  logic          rst_q, nmi_q;

  always_comb begin
    if (timeout_i && !nmi_sel_i)
      rem_d = RW'(RST_W);
    else if (rem_q != '0)
      rem_d = rem_q - 1'b1;
    else
      rem_d = '0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rem_q <= '0;
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      rst_q <= (rem_d != '0);
      nmi_q <= timeout_i && nmi_sel_i;
    end
  end

  assign rst_o = rst_q;
  assign nmi_o = nmi_q;

  // checker: length of each high phase of the reset pulse
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        hi_cnt <= '0;
    else if (rst_q)    hi_cnt <= hi_cnt + 1'b1;
    else               hi_cnt <= '0;
  end

  p_rst_width_r5: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_q) |-> hi_cnt == HW'(RST_W));

  p_nmi_single_r6: assert property (@(posedge clk) disable iff (!por_n)
    nmi_q |=> !nmi_q);

  p_nmi_no_rst_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(nmi_q) |-> !$rose(rst_q));

endmodule

// File: rtl/wdog_nmi_timer.sv
module wdog_nmi_timer
  import wdog_pkg::*;
#(
  parameter int unsigned EXP0      = 18,
  parameter int unsigned EXP1      = 22,
  parameter int unsigned EXP2      = 25,
  parameter int unsigned EXP3      = 27,
  parameter int unsigned RST_W     = 64,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned KICK_ADDR = 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              rst_pulse_o,
  output logic              nmi_o
);

  localparam int unsigned CW = max4(EXP0, EXP1, EXP2, EXP3);

  logic  rst_n;
  logic  hit_ctrl, hit_kick;
  logic  wr_ctrl, wr_kick;
  logic  kick, timeout;
  ctrl_t ctrl;

  assign rst_n    = por_n & sys_rst_n;
  assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
  assign hit_kick = (bus_addr == ADDR_W'(KICK_ADDR));
  assign wr_ctrl  = bus_sel && bus_wr && hit_ctrl;
  assign wr_kick  = bus_sel && bus_wr && hit_kick;

  assign bus_rdata = (bus_sel && !bus_wr && hit_ctrl) ? ctrl : '0;

  wdog_regs u_regs (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .wr_ctrl_i (wr_ctrl),
    .wdata_i   (bus_wdata),
    .timeout_i (timeout),
    .ctrl_o    (ctrl)
  );

  wdog_unlock u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_kick_i (wr_kick),
    .wdata_i   (bus_wdata),
    .kick_o    (kick)
  );

  wdog_counter #(
    .EXP0 (EXP0), .EXP1 (EXP1), .EXP2 (EXP2), .EXP3 (EXP3), .CW (CW)
  ) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (ctrl.en),
    .per_i     (ctrl.per),
    .kick_i    (kick),
    .timeout_o (timeout)
  );

  wdog_pulse #(.RST_W (RST_W)) u_pulse (
    .clk       (clk),
    .por_n     (por_n),
    .timeout_i (timeout),
    .nmi_sel_i (ctrl.nmi_sel),
    .rst_o     (rst_pulse_o),
    .nmi_o     (nmi_o)
  );

  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!por_n)
    bus_rdata[4:2] == 3'b000);

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> !nmi_o);

endmodule

// File: tb/wdog_nmi_timer_test.sv
module wdog_nmi_timer_test;

  localparam int unsigned E0 = 6, E1 = 8, E2 = 9, E3 = 10;
  localparam int unsigned PW = 64;
  localparam int K_RST_UP = 0, K_RST_DN = 1, K_NMI_UP = 2, K_NMI_DN = 3;

  typedef struct {
    int     kind;
    longint at;
    string  tag;
  } ev_t;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, sys_rst_n = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rst_pulse_o, nmi_o;

  int     checks = 0, errors = 0;
  longint cyc = 0;
  bit     done = 1'b0;
  ev_t    exp_q [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_nmi_timer #(
    .EXP0 (E0), .EXP1 (E1), .EXP2 (E2), .EXP3 (E3), .RST_W (PW)
  ) uut (
    .clk (clk), .por_n (por_n), .sys_rst_n (sys_rst_n),
    .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .rst_pulse_o (rst_pulse_o), .nmi_o (nmi_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int kind, input longint at, input string tag);
    ev_t e;
    e.kind = kind; e.at = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output longint edge_at);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    edge_at = cyc;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic wait_until(input longint c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic sys_reset();
    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
  endtask

  // monitor: every output transition must match the head of the queue
  logic prev_rst = 1'b0, prev_nmi = 1'b0;
  always @(negedge clk) begin : mon
    ev_t e;
    int  kind;
    if (rst_pulse_o != prev_rst || nmi_o != prev_nmi) begin
      if (rst_pulse_o != prev_rst) kind = rst_pulse_o ? K_RST_UP : K_RST_DN;
      else                         kind = nmi_o ? K_NMI_UP : K_NMI_DN;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1/R6 unexpected output edge", kind, -1);
      end else begin
        e = exp_q.pop_front();
        chk(kind == e.kind && cyc == e.at, e.tag,
            (longint'(kind) << 32) | cyc, (longint'(e.kind) << 32) | e.at);
      end
    end
    prev_rst = rst_pulse_o;
    prev_nmi = nmi_o;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired, %0d events pending", exp_q.size());
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    longint e, r, unused_e;
    repeat (3) @(negedge clk);
    por_n = 1'b1;

    // R1: reset state, quiet while disabled
    rd_chk(2'd0, 8'h00, "R1 control after power-on");
    chk(!rst_pulse_o && !nmi_o, "R1 outputs low after power-on", {rst_pulse_o, nmi_o}, 0);
    wait_until(cyc + 1200);
    chk(!rst_pulse_o && !nmi_o && exp_q.size() == 0, "R1 no time-out while disabled",
        {rst_pulse_o, nmi_o}, 0);

    // R11: reserved bits and refresh address read zero
    wr(2'd0, 8'h1C, unused_e);
    rd_chk(2'd0, 8'h00, "R11 reserved bits read zero");
    rd_chk(2'd1, 8'h00, "R11 refresh address reads zero");

    // R3 period 0 / R5 reset pulse / R4 flag / R9 flag kept, pulse runs on
    wr(2'd0, 8'h80, e);
    push(K_RST_UP, e + (1 << E0), "R3 R5 reset pulse rise, period 0");
    push(K_RST_DN, e + (1 << E0) + PW, "R5 reset pulse width");
    wait_until(e + (1 << E0) + 6);
    rd_chk(2'd0, 8'hC0, "R4 flag set after time-out");
    sys_reset();
    rd_chk(2'd0, 8'h40, "R9 flag kept through system reset");
    wait_until(e + (1 << E0) + PW + 10);
    chk(exp_q.size() == 0, "R9 reset pulse completed", exp_q.size(), 0);

    // R4: write 1 clears flag
    wr(2'd0, 8'h40, unused_e);
    rd_chk(2'd0, 8'h00, "R4 flag cleared by writing 1");

    // R2 sticky enable, R7 refresh, R8 ignored sequences, period 3
    wr(2'd0, 8'h83, e);
    wr(2'd0, 8'h03, unused_e);
    rd_chk(2'd0, 8'h83, "R2 enable cannot be cleared");
    wait_until(e + 500);
    wr(2'd1, 8'hA5, unused_e);
    wr(2'd1, 8'h5A, r);
    wait_until(r + 300);
    wr(2'd1, 8'h5A, unused_e);
    wr(2'd1, 8'hA5, unused_e);
    wr(2'd1, 8'h00, unused_e);
    wr(2'd1, 8'h5A, unused_e);
    push(K_RST_UP, r + (1 << E3), "R7 R8 time-out measured from valid refresh");
    push(K_RST_DN, r + (1 << E3) + PW, "R5 reset pulse width, period 3");
    wait_until(r + (1 << E3) + 4);
    sys_reset();
    wait_until(r + (1 << E3) + PW + 10);
    chk(exp_q.size() == 0, "R7 refresh events consumed", exp_q.size(), 0);

    // R6 NMI mode, R10 restart, period 1
    wr(2'd0, 8'h40, unused_e);
    wr(2'd0, 8'hA1, e);
    push(K_NMI_UP, e + (1 << E1), "R6 NMI rise, period 1");
    push(K_NMI_DN, e + (1 << E1) + 1, "R6 NMI single cycle");
    push(K_NMI_UP, e + 2 * (1 << E1), "R10 second NMI one period later");
    push(K_NMI_DN, e + 2 * (1 << E1) + 1, "R10 second NMI single cycle");
    wait_until(e + 2 * (1 << E1) + 4);
    rd_chk(2'd0, 8'hE1, "R4 R6 flag set in NMI mode");
    chk(!rst_pulse_o, "R6 no reset pulse in NMI mode", rst_pulse_o, 0);
    sys_reset();

    // R3 period 2 in NMI mode
    wr(2'd0, 8'h40, unused_e);
    wr(2'd0, 8'hA2, e);
    push(K_NMI_UP, e + (1 << E2), "R3 NMI rise, period 2");
    push(K_NMI_DN, e + (1 << E2) + 1, "R6 NMI single cycle, period 2");
    wait_until(e + (1 << E2) + 4);
    sys_reset();
    chk(exp_q.size() == 0, "R3 period 2 events consumed", exp_q.size(), 0);

    // R9: power-on reset clears flag
    rd_chk(2'd0, 8'h40, "R9 flag set before power-on reset");
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rd_chk(2'd0, 8'h00, "R9 power-on reset clears flag");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule